// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Three-Bit Instruction Decoder

This block is the test access port of a memory device. A sixteen-state controller advances on each rising edge of the test clock under control of the mode-select input. It routes the serial data input into one of four shift paths: a three-bit instruction register, a one-bit bypass stage, a 32-bit identification register, or a boundary chain whose length is a parameter and which samples the device pads. The serial output changes on the falling edge of the test clock. It is enabled only while a shift state is active. The block has no test-reset pin. A power-on reset places the controller in Test-Logic-Reset, and holding mode-select high for five clocks returns it there from any state. Board-level pull-ups make undriven mode-select and data inputs read as 1, so the controller stays in Test-Logic-Reset when nothing drives it.

The instruction map has two boundary-sampling instructions. One floats the memory data pins through the `dq_hiz` flag so that every input can be observed. The other leaves the pins driven. A third instruction drives the boundary chain onto the pads. Unused codes behave as bypass. The block exposes the capture and update strobes of the data path and the code of the selected data register, so that the pad logic around it can follow the scan. Data from the memory array never reaches the scan output.

Top module: `jtag_tap`

## Requirements
- R1: The controller follows the standard sixteen-state diagram with separate data and instruction branches, including the Pause, Exit1 and Exit2 loop back into Shift. A shift sequence that passes through Pause and Exit2 loses no data.
- R2: Power-on reset (`por_n` low) puts the controller in Test-Logic-Reset and loads IDCODE into the instruction register. Five rising clocks with `tms` high reach the same state from any state. While the controller is in Test-Logic-Reset the instruction register is reloaded with IDCODE on each clock.
- R3: Instruction decoding: 000 drives the pads from the boundary chain, 001 is IDCODE, 010 samples with floated pins, 100 samples with pins driven, and 111 is BYPASS. `dr_sel` reports 2'b00 for bypass, 2'b01 for the identification register and 2'b10 for the boundary chain.
- R4: `dq_hiz` is 1 only for instruction codes 000 and 010. Code 100 leaves it at 0.
- R5: Under IDCODE, Capture-DR loads the identification value. Shift-DR then emits it least significant bit first, and the TDI bits follow it after 32 shifts.
- R6: Under BYPASS, Capture-DR clears the bypass stage, so the first bit out is 0. Each later bit out is the TDI bit shifted in one clock earlier, and the stage keeps the last shifted bit after the controller leaves Shift-DR.
- R7: The reserved codes 011, 101 and 110 select the bypass stage and behave exactly like BYPASS.
- R8: Capture-IR loads 01 into the two low bits of the instruction shift register, so the first two bits that leave Shift-IR are 1 and then 0.
- R9: `tdo` and `tdo_en` change only on the falling edge of `tck`. `tdo_en` is 1 only while the controller is in Shift-DR or Shift-IR, and `tdo` reads 0 whenever `tdo_en` is 0.
- R10: A newly shifted instruction, together with its `dr_sel` and `dq_hiz`, takes effect only when the controller passes through Update-IR. Until then the previous instruction stays in force.
- R11: When the boundary chain is selected, Capture-DR samples `pad_in` and Shift-DR emits it least significant bit first. The shifted-in bits appear on `bsr_out` only on the clock that leaves Update-DR.
- R12: `capture_dr` is high exactly while the controller is in Capture-DR, and `update_dr` is high exactly while it is in Update-DR. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| tms | input | 1 | Mode select, sampled on the rising edge of tck |
| tdi | input | 1 | Serial data in, sampled on the rising edge of tck |
| pad_in | input | BSR_LEN | Pad values sampled by the boundary chain |
| tdo | output | 1 | Serial data out, updated on the falling edge of tck |
| tdo_en | output | 1 | Output enable for tdo |
| dq_hiz | output | 1 | Forces the memory data pins to high impedance |
| dr_sel | output | 2 | Selected data register (00 bypass, 01 identification, 10 boundary) |
| capture_dr | output | 1 | High in Capture-DR |
| update_dr | output | 1 | High in Update-DR |
| bsr_out | output | BSR_LEN | Boundary values held after Update-DR |

## Verification
The bench targets the timing of instruction changes. A design that applies an instruction as soon as it is shifted would switch `dq_hiz` or `dr_sel` while the controller is still in Exit1-IR. It also targets the data registers. An identification register that does not feed TDI into its top bit would return stale bits after the 32nd shift, and a bypass stage that is not cleared on capture would emit the previous scan's last bit first. A detour through Pause-DR and Exit2-DR in the middle of a shift catches a controller that drops or repeats a bit on that path. Sampling `tdo_en` just after the rising edge that enters Shift-DR catches an output stage clocked on the wrong edge. The reserved codes and both sampling instructions are checked for their bypass routing and for the state of the pin-float flag.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

   localparam int IR_W = 3;

   typedef enum logic [3:0] {
      TS_RESET  = 4'd0,
      TS_IDLE   = 4'd1,
      TS_SEL_DR = 4'd2,
      TS_CAP_DR = 4'd3,
      TS_SHF_DR = 4'd4,
      TS_EX1_DR = 4'd5,
      TS_PAU_DR = 4'd6,
      TS_EX2_DR = 4'd7,
      TS_UPD_DR = 4'd8,
      TS_SEL_IR = 4'd9,
      TS_CAP_IR = 4'd10,
      TS_SHF_IR = 4'd11,
      TS_EX1_IR = 4'd12,
      TS_PAU_IR = 4'd13,
      TS_EX2_IR = 4'd14,
      TS_UPD_IR = 4'd15
   } tap_state_e;

   typedef enum logic [1:0] {
      DR_BYPASS = 2'b00,
      DR_IDENT  = 2'b01,
      DR_BSCAN  = 2'b10
   } dr_sel_e;

   localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
   localparam logic [IR_W-1:0] OP_IDCODE  = 3'b001;
   localparam logic [IR_W-1:0] OP_SAMPLEZ = 3'b010;
   localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b100;
   localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;

   function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
      tap_state_e n;
      case (s)
         TS_RESET:  n = m ? TS_RESET  : TS_IDLE;
         TS_IDLE:   n = m ? TS_SEL_DR : TS_IDLE;
         TS_SEL_DR: n = m ? TS_SEL_IR : TS_CAP_DR;
         TS_CAP_DR: n = m ? TS_EX1_DR : TS_SHF_DR;
         TS_SHF_DR: n = m ? TS_EX1_DR : TS_SHF_DR;
         TS_EX1_DR: n = m ? TS_UPD_DR : TS_PAU_DR;
         TS_PAU_DR: n = m ? TS_EX2_DR : TS_PAU_DR;
         TS_EX2_DR: n = m ? TS_UPD_DR : TS_SHF_DR;
         TS_UPD_DR: n = m ? TS_SEL_DR : TS_IDLE;
         TS_SEL_IR: n = m ? TS_RESET  : TS_CAP_IR;
         TS_CAP_IR: n = m ? TS_EX1_IR : TS_SHF_IR;
         TS_SHF_IR: n = m ? TS_EX1_IR : TS_SHF_IR;
         TS_EX1_IR: n = m ? TS_UPD_IR : TS_PAU_IR;
         TS_PAU_IR: n = m ? TS_EX2_IR : TS_PAU_IR;
         TS_EX2_IR: n = m ? TS_UPD_IR : TS_SHF_IR;
         default:   n = m ? TS_SEL_DR : TS_IDLE;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/jtag_tap_fsm.sv
module jtag_tap_fsm
   import jtag_tap_pkg::*;
(
   input  logic       tck,
   input  logic       por_n,
   input  logic       tms,
   output tap_state_e state_q
);

   tap_state_e state_d;

   always_comb state_d = tap_next(state_q, tms);

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n) state_q <= TS_RESET;
      else        state_q <= state_d;
   end

endmodule

// File: rtl/jtag_tap_ir.sv
module jtag_tap_ir
   import jtag_tap_pkg::*;
(
   input  logic            tck,
   input  logic            por_n,
   input  logic            tdi,
   input  tap_state_e      state_q,
   output logic [IR_W-1:0] ir_q,
   output logic            ir_lsb
);

   localparam logic [IR_W-1:0] CAP_PATTERN = {{(IR_W-2){1'b0}}, 2'b01};

   logic [IR_W-1:0] ir_sh;

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n) begin
         ir_sh <= '0;
         ir_q  <= OP_IDCODE;
      end else begin
         case (state_q)
            TS_RESET:  ir_q  <= OP_IDCODE;
            TS_CAP_IR: ir_sh <= CAP_PATTERN;
            TS_SHF_IR: ir_sh <= {tdi, ir_sh[IR_W-1:1]};
            TS_UPD_IR: ir_q  <= ir_sh;
            default:   ;
         endcase
      end
   end

   assign ir_lsb = ir_sh[0];

endmodule

// File: rtl/jtag_tap_dr.sv
module jtag_tap_dr
   import jtag_tap_pkg::*;
#(
   parameter int          BSR_LEN  = 20,
   parameter logic [31:0] ID_CODE  = 32'h4D7A_1C2B,
   parameter bit          BSR_HOLD = 1'b1
) (
   input  logic               tck,
   input  logic               por_n,
   input  logic               tdi,
   input  tap_state_e         state_q,
   input  dr_sel_e            dr_sel,
   input  logic [BSR_LEN-1:0] pad_in,
   output logic               dr_lsb,
   output logic [BSR_LEN-1:0] bsr_out
);

   localparam int ID_W = 32;

   logic               cap, shf, upd;
   logic               byp_q;
   logic [ID_W-1:0]    id_sh;
   logic [BSR_LEN-1:0] bsr_sh;
   logic               bsr_on;

   assign cap    = (state_q == TS_CAP_DR);
   assign shf    = (state_q == TS_SHF_DR);
   assign upd    = (state_q == TS_UPD_DR);
   assign bsr_on = (dr_sel == DR_BSCAN);

   // bypass stage: cleared on capture, holds the last shifted bit
   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n)                                byp_q <= 1'b0;
      else if (dr_sel == DR_BYPASS && cap)       byp_q <= 1'b0;
      else if (dr_sel == DR_BYPASS && shf)       byp_q <= tdi;
   end

   // identification register, TDI enters at the top
   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n)                                id_sh <= ID_CODE;
      else if (dr_sel == DR_IDENT && cap)        id_sh <= ID_CODE;
      else if (dr_sel == DR_IDENT && shf)        id_sh <= {tdi, id_sh[ID_W-1:1]};
   end

   // boundary chain cells
   for (genvar i = 0; i < BSR_LEN; i++) begin : g_cell
      logic nxt;
      logic cell_q;
      if (i == BSR_LEN - 1) begin : g_last
         assign nxt = tdi;
      end else begin : g_mid
         assign nxt = bsr_sh[i+1];
      end
      always_ff @(posedge tck or negedge por_n) begin
         if (!por_n)               cell_q <= 1'b0;
         else if (bsr_on && cap)   cell_q <= pad_in[i];
         else if (bsr_on && shf)   cell_q <= nxt;
      end
      assign bsr_sh[i] = cell_q;
   end

   // parallel output stage variant
   if (BSR_HOLD) begin : g_hold
      logic [BSR_LEN-1:0] hold_q;
      always_ff @(posedge tck or negedge por_n) begin
         if (!por_n)              hold_q <= '0;
         else if (bsr_on && upd)  hold_q <= bsr_sh;
      end
      assign bsr_out = hold_q;
   end else begin : g_flow
      assign bsr_out = bsr_sh;
   end

   always_comb begin
      case (dr_sel)
         DR_IDENT: dr_lsb = id_sh[0];
         DR_BSCAN: dr_lsb = bsr_sh[0];
         default:  dr_lsb = byp_q;
      endcase
   end

endmodule

// File: rtl/jtag_tap.sv
module jtag_tap
   import jtag_tap_pkg::*;
#(
   parameter int          BSR_LEN  = 20,
   parameter logic [31:0] ID_CODE  = 32'h4D7A_1C2B,
   parameter bit          BSR_HOLD = 1'b1
) (
   input  logic               tck,
   input  logic               por_n,
   input  logic               tms,
   input  logic               tdi,
   input  logic [BSR_LEN-1:0] pad_in,
   output logic               tdo,
   output logic               tdo_en,
   output logic               dq_hiz,
   output logic [1:0]         dr_sel,
   output logic               capture_dr,
   output logic               update_dr,
   output logic [BSR_LEN-1:0] bsr_out
);

   if (BSR_LEN < 2) begin : g_bad_len
      $error("jtag_tap: BSR_LEN must be at least 2");
   end
   if (ID_CODE[0] != 1'b1) begin : g_bad_id
      $error("jtag_tap: ID_CODE bit 0 must be 1");
   end

   tap_state_e      state_q;
   logic [IR_W-1:0] ir_q;
   logic            ir_lsb;
   logic            dr_lsb;
   dr_sel_e         sel;
   logic            hiz;
   logic            tdo_q;
   logic            en_q;
   logic            in_shift;
   logic            shift_bit;

   jtag_tap_fsm u_fsm (
      .tck     (tck),
      .por_n   (por_n),
      .tms     (tms),
      .state_q (state_q)
   );

   jtag_tap_ir u_ir (
      .tck     (tck),
      .por_n   (por_n),
      .tdi     (tdi),
      .state_q (state_q),
      .ir_q    (ir_q),
      .ir_lsb  (ir_lsb)
   );

   always_comb begin
      sel = DR_BYPASS;
      hiz = 1'b0;
      case (ir_q)
         OP_EXTEST:  begin sel = DR_BSCAN; hiz = 1'b1; end
         OP_SAMPLEZ: begin sel = DR_BSCAN; hiz = 1'b1; end
         OP_SAMPLE:  sel = DR_BSCAN;
         OP_IDCODE:  sel = DR_IDENT;
         default:    sel = DR_BYPASS;
      endcase
   end

   jtag_tap_dr #(
      .BSR_LEN  (BSR_LEN),
      .ID_CODE  (ID_CODE),
      .BSR_HOLD (BSR_HOLD)
   ) u_dr (
      .tck     (tck),
      .por_n   (por_n),
      .tdi     (tdi),
      .state_q (state_q),
      .dr_sel  (sel),
      .pad_in  (pad_in),
      .dr_lsb  (dr_lsb),
      .bsr_out (bsr_out)
   );

   assign in_shift  = (state_q == TS_SHF_DR) || (state_q == TS_SHF_IR);
   assign shift_bit = (state_q == TS_SHF_IR) ? ir_lsb : dr_lsb;

   always_ff @(negedge tck or negedge por_n) begin
      if (!por_n) begin
         tdo_q <= 1'b0;
         en_q  <= 1'b0;
      end else begin
         tdo_q <= in_shift ? shift_bit : 1'b0;
         en_q  <= in_shift;
      end
   end

   assign tdo        = en_q ? tdo_q : 1'b0;
   assign tdo_en     = en_q;
   assign dq_hiz     = hiz;
   assign dr_sel     = sel;
   assign capture_dr = (state_q == TS_CAP_DR);
   assign update_dr  = (state_q == TS_UPD_DR);

endmodule

// File: rtl/jtag_tap_chk.sv
module jtag_tap_chk
   import jtag_tap_pkg::*;
(
   input logic            tck,
   input logic            por_n,
   input logic            tms,
   input tap_state_e      state_q,
   input logic [IR_W-1:0] ir_q,
   input logic            dq_hiz,
   input logic            tdo,
   input logic            tdo_en,
   input logic            capture_dr,
   input logic            update_dr
);

   // R2
   tlr_hold_chk: assert property (@(posedge tck) disable iff (!por_n)
      (state_q == TS_RESET && tms) |=> state_q == TS_RESET);

   // R2
   tlr_idcode_chk: assert property (@(posedge tck) disable iff (!por_n)
      state_q == TS_RESET |=> ir_q == OP_IDCODE);

   // R10
   ir_stable_chk: assert property (@(posedge tck) disable iff (!por_n)
      (state_q != TS_UPD_IR && state_q != TS_RESET) |=> $stable(ir_q));

   // R10
   hiz_rise_chk: assert property (@(posedge tck) disable iff (!por_n)
      $rose(dq_hiz) |-> $past(state_q) == TS_UPD_IR);

   // R9
   tdo_en_chk: assert property (@(posedge tck) disable iff (!por_n)
      tdo_en |-> (state_q == TS_SHF_DR || state_q == TS_SHF_IR));

   // R8
   ir_capture_chk: assert property (@(posedge tck) disable iff (!por_n)
      (state_q == TS_SHF_IR && $past(state_q) == TS_CAP_IR) |-> tdo);

   // R12
   strobe_excl_chk: assert property (@(posedge tck) disable iff (!por_n)
      $onehot0({capture_dr, update_dr}));

endmodule

bind jtag_tap jtag_tap_chk chk_i (
   .tck        (tck),
   .por_n      (por_n),
   .tms        (tms),
   .state_q    (state_q),
   .ir_q       (ir_q),
   .dq_hiz     (dq_hiz),
   .tdo        (tdo),
   .tdo_en     (tdo_en),
   .capture_dr (capture_dr),
   .update_dr  (update_dr)
);

// File: tb/jtag_tap_tb_top.sv
module jtag_tap_tb_top;

   localparam int          BSR_LEN = 20;
   localparam logic [31:0] ID      = 32'h4D7A_1C2B;

   // {code[2:0], dr_sel[1:0], dq_hiz}
   localparam logic [5:0] VEC [8] = '{
      6'b000_10_1, 6'b001_01_0, 6'b010_10_1, 6'b011_00_0,
      6'b100_10_0, 6'b101_00_0, 6'b110_00_0, 6'b111_00_0
   };

   logic               tck = 1'b0;
   logic               por_n = 1'b0;
   logic               tms = 1'b1;
   logic               tdi = 1'b1;
   logic [BSR_LEN-1:0] pad_in = '0;
   logic               tdo, tdo_en, dq_hiz, capture_dr, update_dr;
   logic [1:0]         dr_sel;
   logic [BSR_LEN-1:0] bsr_out;

   int checks = 0;
   int errors = 0;

   always #10 tck = ~tck;

   jtag_tap #(.BSR_LEN(BSR_LEN), .ID_CODE(ID), .BSR_HOLD(1'b1)) dut_i (
      .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .pad_in(pad_in),
      .tdo(tdo), .tdo_en(tdo_en), .dq_hiz(dq_hiz), .dr_sel(dr_sel),
      .capture_dr(capture_dr), .update_dr(update_dr), .bsr_out(bsr_out)
   );

   task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
      end
   endtask

   task automatic clk_bit(input logic m, input logic d, output logic o);
      @(negedge tck); #2;
      o   = tdo;
      tms = m;
      tdi = d;
      @(posedge tck); #2;
   endtask

   task automatic step(input logic m);
      logic o;
      clk_bit(m, 1'b1, o);
   endtask

   task automatic load_ir(input logic [2:0] code, output logic [2:0] cap);
      logic b;
      step(1'b1); step(1'b1); step(1'b0); step(1'b0);
      for (int i = 0; i < 3; i++) begin
         clk_bit(i == 2, code[i], b);
         cap[i] = b;
      end
      step(1'b1); step(1'b0);
   endtask

   task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
      logic b;
      step(1'b1); step(1'b0); step(1'b0);
      dout = '0;
      for (int i = 0; i < n; i++) begin
         clk_bit(i == n - 1, din[i], b);
         dout[i] = b;
      end
      step(1'b1); step(1'b0);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(20 * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [2:0]  cap;
      logic [63:0] dout;
      logic        o1, o2, o3;

      repeat (3) @(posedge tck);
      @(negedge tck); por_n = 1'b1;
      #2;
      // R2 reset state
      chk("R2 sel after reset", dr_sel, 2'b01);
      chk("R2 hiz after reset", dq_hiz, 1'b0);
      chk("R9 tdo_en after reset", tdo_en, 1'b0);
      chk("R9 tdo after reset", tdo, 1'b0);
      step(1'b0);

      // R3 R4 R7 R8 table of instruction codes
      foreach (VEC[e]) begin
         load_ir(VEC[e][5:3], cap);
         chk("R3 dr_sel", dr_sel, VEC[e][2:1]);
         chk("R4 dq_hiz", dq_hiz, VEC[e][0]);
         chk("R8 captured IR bits", cap[1:0], 2'b01);
      end

      // R5 identification register
      load_ir(3'b001, cap);
      scan_dr(40, 64'h0000_0000_1234_5678, dout);
      chk("R5 id value", dout[31:0], ID);
      chk("R5 tdi follows id", dout[39:32], 8'h78);

      // R6 bypass
      load_ir(3'b111, cap);
      scan_dr(8, 64'hB2, dout);
      chk("R6 bypass delay", dout[7:0], {7'h32, 1'b0});

      // R7 reserved code behaves as bypass
      load_ir(3'b101, cap);
      scan_dr(8, 64'h6D, dout);
      chk("R7 reserved bypass", dout[7:0], {7'h6D, 1'b0});

      // R1 R9 R12 pause detour under bypass
      load_ir(3'b111, cap);
      step(1'b1);
      step(1'b0);
      chk("R12 capture_dr in Capture-DR", capture_dr, 1'b1);
      chk("R12 update_dr in Capture-DR", update_dr, 1'b0);
      step(1'b0);
      chk("R9 tdo_en waits for falling edge", tdo_en, 1'b0);
      clk_bit(1'b0, 1'b1, o1);
      chk("R9 tdo_en in Shift-DR", tdo_en, 1'b1);
      chk("R6 first bypass bit", o1, 1'b0);
      clk_bit(1'b1, 1'b0, o2);
      chk("R6 bypass follows tdi", o2, 1'b1);
      step(1'b0); step(1'b0); step(1'b1); step(1'b0);
      clk_bit(1'b1, 1'b1, o3);
      chk("R1 bit held through pause", o3, 1'b0);
      step(1'b1);
      chk("R12 update_dr in Update-DR", update_dr, 1'b1);
      chk("R12 capture_dr in Update-DR", capture_dr, 1'b0);
      step(1'b0);
      @(negedge tck); #2;
      chk("R9 tdo_en off in idle", tdo_en, 1'b0);
      chk("R9 tdo low in idle", tdo, 1'b0);

      // R11 boundary sample with driven pins
      pad_in = 20'hC3A59;
      load_ir(3'b100, cap);
      chk("R4 sample keeps pins driven", dq_hiz, 1'b0);
      scan_dr(BSR_LEN, 64'h5E1D7, dout);
      chk("R11 captured pads", dout[BSR_LEN-1:0], 20'hC3A59);
      chk("R11 update output", bsr_out, 20'h5E1D7);

      // R10 instruction waits for Update-IR
      load_ir(3'b000, cap);
      chk("R4 extest floats pins", dq_hiz, 1'b1);
      step(1'b1); step(1'b1); step(1'b0); step(1'b0);
      clk_bit(1'b0, 1'b1, o1);
      clk_bit(1'b0, 1'b1, o1);
      clk_bit(1'b1, 1'b1, o1);
      chk("R10 hiz unchanged before update", dq_hiz, 1'b1);
      chk("R10 sel unchanged before update", dr_sel, 2'b10);
      step(1'b1); step(1'b0);
      chk("R10 sel after update", dr_sel, 2'b00);
      chk("R10 hiz after update", dq_hiz, 1'b0);

      // R2 five clocks of tms high return to reset
      for (int k = 0; k < 5; k++) step(1'b1);
      chk("R2 tms high reloads idcode", dr_sel, 2'b01);
      step(1'b0);

      // R2 power-on reset in mid run
      load_ir(3'b111, cap);
      @(negedge tck); por_n = 1'b0; #2;
      chk("R2 por restores idcode", dr_sel, 2'b01);
      @(negedge tck); por_n = 1'b1;
      step(1'b0);

      finish_run();
   end

endmodule